// File: doc/BRIEF.md
# RV32 single-cycle execution datapath

This block is the datapath half of a single-cycle RV32 core. Each clock cycle it fetches one instruction, executes it and commits the result. The program counter is the only register in the fetch path. The block reads two register operands and builds the immediate for the instruction's format. It then runs the ALU, drives the data-memory port and writes one result back. The decoder that produces the steering signals sits outside the block. So do the instruction and data memories, which are 64 words of 32 bits each and are indexed by address bits [7:2].

The datapath feeds the opcode, funct3 and bit 30 of the instruction back to the decoder, together with the ALU zero flag. The decoder returns the register write enable, the immediate format, the ALU operand-B source, the ALU operation, the next-PC source and the result source. Besides the usual ALU, load, store and branch paths, the block has two extra write-back paths. One returns PC+4 for jump-and-link. The other returns the upper immediate for lui.

Top module: `rv_sc_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and `imem_addr` shows 0. The first instruction after reset is fetched from address 0.
- R2: Register 0 always reads as zero. A write that targets register 0 leaves it at zero.
- R3: Operand indices come from instruction bits [19:15] (source 1) and [24:20] (source 2). The destination index comes from bits [11:7]. A register is written at the rising edge when `reg_we` is 1. `opcode` shows bits [6:0], `funct3` shows bits [14:12] and `funct7b5` shows bit 30.
- R4: At each rising edge the next PC is PC+4 when `pc_sel` is 0 and PC plus the immediate when `pc_sel` is 1.
- R5: The `imm_kind` codes are as follows. All immediates are sign-extended from instruction bit 31.
  - 0: {[31:20]}
  - 1: {[31:25],[11:7]}
  - 2: {[31],[7],[30:25],[11:8],0}
  - 3: {[31],[19:12],[20],[30:21],0}
  - 4: {[31:12],12'b0}
- R6: The `alu_op` codes are 0 add, 1 subtract, 2 and, 3 or and 5 signed set-less-than. `zero` is 1 exactly when the ALU result is 0. Operand B is the immediate when `alu_src_imm` is 1 and the source-2 register when it is 0.
- R7: `res_sel` selects the write-back value: 0 the ALU result, 1 `dmem_rdata`, 2 PC+4, 3 the immediate.
- R8: `dmem_addr` is the ALU result and `dmem_wdata` is the source-2 register value.
- R9: The reference program makes these stores, in order:

  | Address | Value |
  |---|---|
  | 96 | 7 |
  | 100 | 25 |
  | 104 | 0x0BEEF000 |

  After the last store it settles in a branch-to-self at address 0x58.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| imm_kind | input | 3 | Immediate format code |
| alu_src_imm | input | 1 | ALU operand B takes the immediate |
| alu_op | input | 3 | ALU operation code |
| pc_sel | input | 1 | Next PC is PC plus immediate |
| res_sel | input | 2 | Write-back source |
| imem_addr | output | 32 | Instruction fetch address (the PC) |
| imem_rdata | input | 32 | Fetched instruction |
| dmem_addr | output | 32 | Data memory address |
| dmem_wdata | output | 32 | Data memory store value |
| dmem_rdata | input | 32 | Data memory load value |
| opcode | output | 7 | Instruction bits [6:0] |
| funct3 | output | 3 | Instruction bits [14:12] |
| funct7b5 | output | 1 | Instruction bit 30 |
| zero | output | 1 | ALU result is zero |

## Verification
Jump-and-link is the case where two of the block's functions coincide. In a single cycle it writes PC+4 into the destination register and also moves the PC to the target. The bench provokes this with a forward jal in each of its two programs. The first program's store of 100 depends on the link value 0x44. The second program stores the link register directly and expects 0x34. A wrong link value or a wrong target therefore shows up as a mismatched address or datum in the store scoreboard. A second coincidence is the conditional branch, where the zero flag computed in the same cycle picks the next PC. The taken and not-taken branches of the reference program can only yield the expected store sequence if that choice is made correctly.

// File: rtl/rvdp_pkg.sv
package rvdp_pkg;

  typedef enum logic [2:0] {
    IMM_I = 3'd0,
    IMM_S = 3'd1,
    IMM_B = 3'd2,
    IMM_J = 3'd3,
    IMM_U = 3'd4
  } imm_kind_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd5
  } alu_op_e;

  typedef enum logic [1:0] {
    RES_ALU  = 2'd0,
    RES_MEM  = 2'd1,
    RES_LINK = 2'd2,
    RES_IMM  = 2'd3
  } res_sel_e;

endpackage

// File: rtl/rvdp_regfile.sv
module rvdp_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [XLEN-1:0]         wd,
  output logic [XLEN-1:0]         rd1,
  output logic [XLEN-1:0]         rd2
);
  localparam int RAW = $clog2(NREG);

  logic [XLEN-1:0] regs [NREG];

  // Plain write port without reset, so the array maps to distributed RAM.
  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  // Index 0 is forced to zero on the read side.
  assign rd1 = (ra1 == RAW'(0)) ? '0 : regs[ra1];
  assign rd2 = (ra2 == RAW'(0)) ? '0 : regs[ra2];

endmodule

// File: rtl/rvdp_immgen.sv
module rvdp_immgen
  import rvdp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:7]     ins,
  input  imm_kind_e       kind,
  output logic [XLEN-1:0] imm
);
  logic [31:0] raw;
  logic        sgn;

  assign sgn = ins[31];

  always_comb begin
    unique case (kind)
      IMM_I:   raw = {{20{sgn}}, ins[31:20]};
      IMM_S:   raw = {{20{sgn}}, ins[31:25], ins[11:7]};
      IMM_B:   raw = {{19{sgn}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
      IMM_J:   raw = {{11{sgn}}, ins[31], ins[19:12], ins[20], ins[30:21], 1'b0};
      IMM_U:   raw = {ins[31:12], 12'b0};
      default: raw = '0;
    endcase
  end

  generate
    if (XLEN > 32) begin : g_wide
      assign imm = {{(XLEN-32){raw[31]}}, raw};
    end else begin : g_narrow
      assign imm = raw[XLEN-1:0];
    end
  endgenerate

endmodule

// File: rtl/rvdp_alu.sv
module rvdp_alu
  import rvdp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/rv_sc_datapath.sv
module rv_sc_datapath
  import rvdp_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NREG     = 32,
  parameter int RESET_PC = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [2:0]      imm_kind,
  input  logic            alu_src_imm,
  input  logic [2:0]      alu_op,
  input  logic            pc_sel,
  input  logic [1:0]      res_sel,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic [6:0]      opcode,
  output logic [2:0]      funct3,
  output logic            funct7b5,
  output logic            zero
);
  localparam int              RAW     = $clog2(NREG);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);
  localparam logic [XLEN-1:0] PC_RST  = XLEN'(RESET_PC);

  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, pc_target;
  logic [RAW-1:0]  rs1_idx, rs2_idx, rd_idx;
  logic [XLEN-1:0] rs1_data, rs2_data;
  logic [XLEN-1:0] imm_val, alu_b, alu_y, wb_data;
  alu_op_e         op_e;
  res_sel_e        res_e;
  imm_kind_e       kind_e;

  assign op_e   = alu_op_e'(alu_op);
  assign res_e  = res_sel_e'(res_sel);
  assign kind_e = imm_kind_e'(imm_kind);

  // Instruction field split
  assign opcode   = imem_rdata[6:0];
  assign funct3   = imem_rdata[14:12];
  assign funct7b5 = imem_rdata[30];
  assign rs1_idx  = imem_rdata[15 +: RAW];
  assign rs2_idx  = imem_rdata[20 +: RAW];
  assign rd_idx   = imem_rdata[7 +: RAW];

  // Program counter
  assign pc_plus4  = pc_q + PC_STEP;
  assign pc_target = pc_q + imm_val;
  assign pc_next   = pc_sel ? pc_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= PC_RST;
    else     pc_q <= pc_next;
  end

  assign imem_addr = pc_q;

  rvdp_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk (clk),
    .we  (reg_we),
    .ra1 (rs1_idx),
    .ra2 (rs2_idx),
    .wa  (rd_idx),
    .wd  (wb_data),
    .rd1 (rs1_data),
    .rd2 (rs2_data)
  );

  rvdp_immgen #(.XLEN(XLEN)) u_imm (
    .ins  (imem_rdata[31:7]),
    .kind (kind_e),
    .imm  (imm_val)
  );

  assign alu_b = alu_src_imm ? imm_val : rs2_data;

  rvdp_alu #(.XLEN(XLEN)) u_alu (
    .a    (rs1_data),
    .b    (alu_b),
    .op   (op_e),
    .y    (alu_y),
    .zero (zero)
  );

  assign dmem_addr  = alu_y;
  assign dmem_wdata = rs2_data;

  // Write-back source
  always_comb begin
    unique case (res_e)
      RES_ALU:  wb_data = alu_y;
      RES_MEM:  wb_data = dmem_rdata;
      RES_LINK: wb_data = pc_plus4;
      RES_IMM:  wb_data = imm_val;
      default:  wb_data = alu_y;
    endcase
  end

endmodule

// File: rtl/rv_sc_datapath_chk.sv
module rv_sc_datapath_chk #(
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc,
  input logic            pc_sel,
  input logic [XLEN-1:0] imm,
  input logic [RAW-1:0]  rs1_idx,
  input logic [XLEN-1:0] rs1_data,
  input logic [2:0]      alu_op,
  input logic [XLEN-1:0] alu_a,
  input logic [XLEN-1:0] alu_b,
  input logic            zero,
  input logic [1:0]      res_sel,
  input logic [XLEN-1:0] wb_data
);
  AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    !pc_sel |=> pc == $past(pc) + XLEN'(4)); // R4

  AST_PC_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    pc_sel |=> pc == $past(pc + imm)); // R4

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00); // R4

  AST_X0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rs1_idx == '0) |-> (rs1_data == '0)); // R2

  AST_SUB_EQUAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (alu_op == 3'd1 && alu_a == alu_b) |-> zero); // R6

  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
    (res_sel == 2'd2) |-> (wb_data == pc + XLEN'(4))); // R7

  AST_UPPER_VALUE: assert property (@(posedge clk) disable iff (rst)
    (res_sel == 2'd3) |-> (wb_data == imm)); // R7

endmodule

bind rv_sc_datapath rv_sc_datapath_chk #(.XLEN(XLEN), .RAW(RAW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc_q),
  .pc_sel   (pc_sel),
  .imm      (imm_val),
  .rs1_idx  (rs1_idx),
  .rs1_data (rs1_data),
  .alu_op   (alu_op),
  .alu_a    (rs1_data),
  .alu_b    (alu_b),
  .zero     (zero),
  .res_sel  (res_sel),
  .wb_data  (wb_data)
);

// File: tb/rv_sc_datapath_tb.sv
module rv_sc_datapath_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk; // 50 MHz

  logic        reg_we, alu_src_imm, pc_sel, zero, funct7b5, dmem_we;
  logic [2:0]  imm_kind, alu_op, funct3;
  logic [1:0]  res_sel;
  logic [6:0]  opcode;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } store_t;
  store_t exp_q[$];

  rv_sc_datapath u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .imm_kind(imm_kind),
    .alu_src_imm(alu_src_imm), .alu_op(alu_op), .pc_sel(pc_sel),
    .res_sel(res_sel), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .opcode(opcode), .funct3(funct3), .funct7b5(funct7b5), .zero(zero)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we && !rst) dmem[dmem_addr[7:2]] <= dmem_wdata;

  // Bench-side decoder
  always_comb begin
    reg_we = 1'b0; imm_kind = 3'd0; alu_src_imm = 1'b0; alu_op = 3'd0;
    pc_sel = 1'b0; res_sel = 2'd0; dmem_we = 1'b0;
    case (opcode)
      7'd3:   begin reg_we = 1'b1; alu_src_imm = 1'b1; res_sel = 2'd1; end
      7'd35:  begin imm_kind = 3'd1; alu_src_imm = 1'b1; dmem_we = 1'b1; end
      7'd51, 7'd19: begin
        reg_we = 1'b1;
        alu_src_imm = (opcode == 7'd19);
        case (funct3)
          3'd0:    alu_op = (opcode == 7'd51 && funct7b5) ? 3'd1 : 3'd0;
          3'd2:    alu_op = 3'd5;
          3'd6:    alu_op = 3'd3;
          3'd7:    alu_op = 3'd2;
          default: alu_op = 3'd0;
        endcase
      end
      7'd99:  begin imm_kind = 3'd2; alu_op = 3'd1; pc_sel = zero; end
      7'd111: begin reg_we = 1'b1; imm_kind = 3'd3; pc_sel = 1'b1; res_sel = 2'd2; end
      7'd55:  begin reg_we = 1'b1; imm_kind = 3'd4; res_sel = 2'd3; end
      default: ;
    endcase
  end

  function automatic logic [31:0] e_r(logic [6:0] f7, logic [4:0] b, logic [4:0] a,
                                      logic [2:0] f3, logic [4:0] d);
    return {f7, b, a, f3, d, 7'd51};
  endfunction
  function automatic logic [31:0] e_i(logic [11:0] im, logic [4:0] a, logic [2:0] f3,
                                      logic [4:0] d, logic [6:0] op);
    return {im, a, f3, d, op};
  endfunction
  function automatic logic [31:0] e_s(logic [11:0] im, logic [4:0] b, logic [4:0] a);
    return {im[11:5], b, a, 3'd2, im[4:0], 7'd35};
  endfunction
  function automatic logic [31:0] e_b(logic [12:0] im, logic [4:0] b, logic [4:0] a);
    return {im[12], im[10:5], b, a, 3'd0, im[4:1], im[11], 7'd99};
  endfunction
  function automatic logic [31:0] e_j(logic [20:0] im, logic [4:0] d);
    return {im[20], im[10:1], im[11], im[19:12], d, 7'd111};
  endfunction
  function automatic logic [31:0] e_u(logic [19:0] im, logic [4:0] d);
    return {im, d, 7'd55};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_store(logic [31:0] a, logic [31:0] d, string tag);
    store_t s;
    s.addr = a; s.data = d; s.tag = tag;
    exp_q.push_back(s);
  endtask

  // Monitor: compares every store against the scoreboard
  always @(negedge clk) begin
    if (!rst && dmem_we) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected store", dmem_addr, 32'hFFFF_FFFF);
      end else begin
        store_t s;
        s = exp_q.pop_front();
        check({s.tag, " store address"}, dmem_addr, s.addr);
        check({s.tag, " store data"}, dmem_wdata, s.data);
      end
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0000_0013;
      dmem[i] = 32'h0;
    end
  endtask

  task automatic load_ref();
    clear_mem();
    imem[0]  = e_i(12'd5,   5'd0, 3'd0, 5'd2, 7'd19);
    imem[1]  = e_i(12'd12,  5'd0, 3'd0, 5'd3, 7'd19);
    imem[2]  = e_i(12'hFF7, 5'd3, 3'd0, 5'd7, 7'd19);
    imem[3]  = e_r(7'd0, 5'd2, 5'd7, 3'd6, 5'd4);
    imem[4]  = e_r(7'd0, 5'd4, 5'd3, 3'd7, 5'd5);
    imem[5]  = e_r(7'd0, 5'd4, 5'd5, 3'd0, 5'd5);
    imem[6]  = e_b(13'h030, 5'd7, 5'd5);
    imem[7]  = e_r(7'd0, 5'd4, 5'd3, 3'd2, 5'd4);
    imem[8]  = e_b(13'h008, 5'd0, 5'd4);
    imem[9]  = e_i(12'd0,   5'd0, 3'd0, 5'd5, 7'd19);
    imem[10] = e_r(7'd0, 5'd2, 5'd7, 3'd2, 5'd4);
    imem[11] = e_r(7'd0, 5'd5, 5'd4, 3'd0, 5'd7);
    imem[12] = e_r(7'h20, 5'd2, 5'd7, 3'd0, 5'd7);
    imem[13] = e_s(12'd84, 5'd7, 5'd3);
    imem[14] = e_i(12'd96,  5'd0, 3'd2, 5'd2, 7'd3);
    imem[15] = e_r(7'd0, 5'd5, 5'd2, 3'd0, 5'd9);
    imem[16] = e_j(21'h8, 5'd3);
    imem[17] = e_i(12'd1,   5'd0, 3'd0, 5'd2, 7'd19);
    imem[18] = e_r(7'd0, 5'd9, 5'd2, 3'd0, 5'd2);
    imem[19] = e_s(12'h020, 5'd2, 5'd3);
    imem[20] = e_u(20'h0BEEF, 5'd2);
    imem[21] = e_s(12'h024, 5'd2, 5'd3);
    imem[22] = e_b(13'h0, 5'd2, 5'd2);
  endtask

  task automatic load_corner();
    clear_mem();
    imem[0]  = e_i(12'd77,  5'd0, 3'd0, 5'd0, 7'd19);
    imem[1]  = e_s(12'd0,   5'd0, 5'd0);
    imem[2]  = e_u(20'hFFFFF, 5'd1);
    imem[3]  = e_i(12'h7FF, 5'd1, 3'd6, 5'd1, 7'd19);
    imem[4]  = e_s(12'd4,   5'd1, 5'd0);
    imem[5]  = e_i(12'hFFD, 5'd0, 3'd0, 5'd2, 7'd19);
    imem[6]  = e_i(12'hFFE, 5'd2, 3'd2, 5'd3, 7'd19);
    imem[7]  = e_s(12'd8,   5'd3, 5'd0);
    imem[8]  = e_i(12'h0F0, 5'd2, 3'd7, 5'd4, 7'd19);
    imem[9]  = e_r(7'h20, 5'd4, 5'd0, 3'd0, 5'd5);
    imem[10] = e_i(12'd20,  5'd0, 3'd0, 5'd6, 7'd19);
    imem[11] = e_s(12'hFFC, 5'd5, 5'd6);
    imem[12] = e_j(21'h8, 5'd7);
    imem[13] = e_i(12'd0,   5'd0, 3'd0, 5'd7, 7'd19);
    imem[14] = e_s(12'd20,  5'd7, 5'd0);
    imem[15] = e_b(13'h0, 5'd0, 5'd0);
  endtask

  task automatic run_until_drained(string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 200) begin
      @(posedge clk);
      n++;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({tag, " scoreboard drained"}, 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 5000) begin
      @(posedge clk);
      wd++;
    end
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    load_ref();
    expect_store(32'd96,  32'd7,          "R9");
    expect_store(32'd100, 32'd25,         "R9");
    expect_store(32'd104, 32'h0BEE_F000,  "R9");
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pc in reset", imem_addr, 32'd0);
    check("R3 opcode field", {25'd0, opcode}, 32'h13);
    rst = 1'b0;
    @(negedge clk);
    check("R4 pc after first step", imem_addr, 32'd4);
    run_until_drained("R9");
    check("R9 self loop address", imem_addr, 32'h58);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 self loop holds", imem_addr, 32'h58);
    check("R8 store landed at 104", dmem[26], 32'h0BEE_F000);

    rst = 1'b1;
    load_corner();
    expect_store(32'd0,  32'd0,          "R2");
    expect_store(32'd4,  32'hFFFF_F7FF,  "R5");
    expect_store(32'd8,  32'd1,          "R6");
    expect_store(32'd16, 32'hFFFF_FF10,  "R8");
    expect_store(32'd20, 32'h34,         "R7");
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 pc back to zero", imem_addr, 32'd0);
    rst = 1'b0;
    run_until_drained("R3");
    check("R4 corner loop address", imem_addr, 32'h3C);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule